// File: doc/BRIEF.md
# Update-Protocol Snooping Cache Controller

This block is the private cache controller of one processor in a shared-bus multiprocessor. It keeps every cached copy of a word coherent by broadcasting new values to the other caches, not by invalidating them. Each line holds one word and two state flags: a shared flag that says other caches may hold the word, and a dirty flag that says memory is out of date. A write to a line believed private stays in the cache (write-back). A write to a line believed shared goes onto the bus (write-through), and the line's shared flag is then refreshed from the wired-OR shared signal.

The processor side takes one single-word read or write at a time, held until a one-cycle done pulse. The bus side raises a request, waits for a grant, and then performs a one-cycle transaction: read, write-through, or victim flush. Every cache watches the transactions of the others. A cache that holds the addressed line asserts the shared signal, and a cache that holds it dirty supplies the data on a foreign read. The arbiter, memory and the wired-OR of the shared and supply signals are outside the block. The cache is direct mapped, and the set index is the low address bits.

Top module: `upd_snoop_cache`

## Requirements
- R1: After reset cpu_done_o and bus_req_o are low and every line is invalid, so the first access to any address misses.
- R2: A read that hits returns the cached word with cpu_done_o one cycle after the request is seen, and causes no bus transaction.
- R3: A read miss issues one read transaction (bus_cmd_o = 1). The line is installed private and clean when bus_shared_i is low, and shared and clean when bus_shared_i is high with no supplier.
- R4: A write to a valid line whose shared flag is clear updates the cache only, with no write-through, and leaves the line private and dirty.
- R5: A write to a line whose shared flag is set issues a write-through (bus_cmd_o = 2) carrying the new word. Afterwards the line is clean, and its shared flag equals the bus_shared_i value sampled in the transaction cycle.
- R6: During any transaction of another cache whose address matches a valid line of this cache, snp_shared_o is high. It is never high for this cache's own transaction.
- R7: On another cache's read of a line held dirty here, snp_supply_o is high and snp_data_o carries the word, so memory is not read or written. Both the supplier and the requester end with the line shared and dirty.
- R8: A miss that evicts a dirty line first issues a flush (bus_cmd_o = 3) of the victim's address and word. Other caches holding the victim end shared and clean.
- R9: A write miss first performs the read of R3 and then applies R4 or R5 according to the shared flag just learned.
- R10: A cache holding a line that another cache writes through takes the new word and ends shared and clean.
- R11: While bus_req_o is high and not granted, bus_req_o, bus_cmd_o and bus_addr_o hold their values.
- R12: The set index is the low address bit, so addresses that differ only in the upper bit evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read result, valid with done |
| bus_req_o | output | 1 | Request for the bus |
| bus_gnt_i | input | 1 | Grant; the granted cycle is the transaction cycle |
| bus_cmd_o | output | 2 | Own command: 0 none, 1 read, 2 write-through, 3 flush |
| bus_addr_o | output | ADDR_W | Own transaction address |
| bus_wdata_o | output | DATA_W | Own write-through or flush word |
| bus_valid_i | input | 1 | A transaction is on the bus this cycle |
| bus_cmd_i | input | 2 | Command on the bus |
| bus_addr_i | input | ADDR_W | Address on the bus |
| bus_data_i | input | DATA_W | Resolved bus word (supplier, memory or writer) |
| bus_shared_i | input | 1 | Wired-OR of all snp_shared_o |
| bus_supply_i | input | 1 | Wired-OR of all snp_supply_o |
| snp_shared_o | output | 1 | This cache holds the addressed line |
| snp_supply_o | output | 1 | This cache supplies the word on a foreign read |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
The hardest situations to reach are the ones where a cache's belief about sharing is stale. One case is a write-through to a line that every other cache has since evicted, which must fall back to private. Another is a dirty line held in several caches at once, so that several suppliers drive the bus together. The bench reaches them by replaying conflicting access sequences on the two sets across three instances, followed by a long pseudo-random sweep of processor, operation and address. A bench-side model of each line's flags predicts the transaction counts, the shared and supply observations, and the memory image for every operation. A final phase issues simultaneous reads of a dirty word from all three processors to exercise arbitration waits and multiple suppliers.

// File: rtl/upd_cache_pkg.sv
package upd_cache_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WTHRU = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_FILL,
    ST_WTHRU,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/upd_line_store.sv
module upd_line_store #(
  parameter int SETS   = 2,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic              wval_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic              wshd_i,
  input  logic              wdty_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  aidx_i,
  output logic              a_val_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic              a_shd_o,
  output logic              a_dty_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  bidx_i,
  output logic              b_val_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic              b_shd_o,
  output logic              b_dty_o,
  output logic [DATA_W-1:0] b_data_o
);
  logic [SETS-1:0]   vld_q, shd_q, dty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        shd_q[s] <= 1'b0;
        dty_q[s] <= 1'b0;
      end else if (sel) begin
        vld_q[s] <= wval_i;
        shd_q[s] <= wshd_i;
        dty_q[s] <= wdty_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[s]  <= wtag_i;
        data_q[s] <= wdata_i;
      end
    end
  end

  assign a_val_o  = vld_q[aidx_i];
  assign a_tag_o  = tag_q[aidx_i];
  assign a_shd_o  = shd_q[aidx_i];
  assign a_dty_o  = dty_q[aidx_i];
  assign a_data_o = data_q[aidx_i];

  assign b_val_o  = vld_q[bidx_i];
  assign b_tag_o  = tag_q[bidx_i];
  assign b_shd_o  = shd_q[bidx_i];
  assign b_dty_o  = dty_q[bidx_i];
  assign b_data_o = data_q[bidx_i];
endmodule

// File: rtl/upd_snoop_unit.sv
module upd_snoop_unit
  import upd_cache_pkg::*;
#(
  parameter int TAG_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              foreign_i,
  input  logic [1:0]        cmd_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              l_val_i,
  input  logic [TAG_W-1:0]  l_tag_i,
  input  logic              l_dty_i,
  input  logic [DATA_W-1:0] l_data_i,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] sdata_o,
  output logic              upd_we_o,
  output logic              upd_dty_o,
  output logic [DATA_W-1:0] upd_data_o
);
  bus_cmd_e cmd;
  logic     hit;

  assign cmd      = bus_cmd_e'(cmd_i);
  assign hit      = foreign_i && l_val_i && (l_tag_i == tag_i);
  assign shared_o = hit;
  assign supply_o = hit && (cmd == CMD_READ) && l_dty_i;
  assign sdata_o  = l_data_i;

  // every snooped hit leaves the line shared; only reads keep dirtiness
  always_comb begin
    upd_we_o   = hit;
    upd_dty_o  = 1'b0;
    upd_data_o = l_data_i;
    case (cmd)
      CMD_READ:  upd_dty_o  = l_dty_i;
      CMD_WTHRU: upd_data_o = data_i;
      default:   upd_dty_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/upd_ctrl_fsm.sv
module upd_ctrl_fsm
  import upd_cache_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              breq_o,
  output logic [1:0]        cmd_o,
  output logic [ADDR_W-1:0] baddr_o,
  output logic [DATA_W-1:0] bwdata_o,
  input  logic              bgnt_i,
  input  logic              foreign_i,
  input  logic              shared_i,
  input  logic              supply_i,
  input  logic [DATA_W-1:0] bdata_i,
  output logic [IDX_W-1:0]  lidx_o,
  input  logic              l_val_i,
  input  logic [TAG_W-1:0]  l_tag_i,
  input  logic              l_shd_i,
  input  logic              l_dty_i,
  input  logic [DATA_W-1:0] l_data_i,
  output logic              lwe_o,
  output logic [TAG_W-1:0]  ltag_o,
  output logic              lshd_o,
  output logic              ldty_o,
  output logic [DATA_W-1:0] ldata_o
);
  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] r_addr_q, cur_addr;
  logic              r_we_q;
  logic [DATA_W-1:0] r_wdata_q, rdata_q, rdata_d;
  logic              cap, hit;
  logic [TAG_W-1:0]  cur_tag;

  assign cur_addr = (state_q == ST_IDLE) ? addr_i : r_addr_q;
  assign lidx_o   = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign hit      = l_val_i && (l_tag_i == cur_tag);
  assign ltag_o   = cur_tag;

  always_comb begin
    state_d  = state_q;
    cap      = 1'b0;
    rdata_d  = rdata_q;
    done_o   = 1'b0;
    breq_o   = 1'b0;
    cmd_o    = CMD_NONE;
    baddr_o  = r_addr_q;
    bwdata_o = r_wdata_q;
    lwe_o    = 1'b0;
    lshd_o   = 1'b0;
    ldty_o   = 1'b0;
    ldata_o  = r_wdata_q;
    case (state_q)
      ST_IDLE: begin
        // hold off while another cache's transaction may touch the array
        if (req_i && !foreign_i) begin
          cap = 1'b1;
          if (hit) begin
            if (!we_i) begin
              rdata_d = l_data_i;
              state_d = ST_DONE;
            end else if (!l_shd_i) begin
              lwe_o   = 1'b1;
              ldty_o  = 1'b1;
              ldata_o = wdata_i;
              state_d = ST_DONE;
            end else begin
              state_d = ST_WTHRU;
            end
          end else begin
            state_d = (l_val_i && l_dty_i) ? ST_FLUSH : ST_FILL;
          end
        end
      end
      ST_FLUSH: begin
        breq_o   = 1'b1;
        cmd_o    = CMD_FLUSH;
        baddr_o  = {l_tag_i, lidx_o};
        bwdata_o = l_data_i;
        if (bgnt_i) begin
          lwe_o   = 1'b1;
          lshd_o  = l_shd_i;
          ldata_o = l_data_i;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        breq_o = 1'b1;
        cmd_o  = CMD_READ;
        if (bgnt_i) begin
          lwe_o = 1'b1;
          if (r_we_q && !shared_i) begin
            ldty_o  = 1'b1;
            state_d = ST_DONE;
          end else begin
            lshd_o  = shared_i;
            ldty_o  = supply_i;
            ldata_o = bdata_i;
            rdata_d = bdata_i;
            state_d = r_we_q ? ST_WTHRU : ST_DONE;
          end
        end
      end
      ST_WTHRU: begin
        breq_o = 1'b1;
        cmd_o  = CMD_WTHRU;
        if (bgnt_i) begin
          lwe_o   = 1'b1;
          lshd_o  = shared_i;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      r_addr_q  <= '0;
      r_we_q    <= 1'b0;
      r_wdata_q <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
      if (cap) begin
        r_addr_q  <= addr_i;
        r_we_q    <= we_i;
        r_wdata_q <= wdata_i;
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/upd_snoop_cache.sv
module upd_snoop_cache #(
  parameter int ADDR_W = 2,
  parameter int IDX_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  input  logic              bus_supply_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              foreign;
  logic [IDX_W-1:0]  c_idx, s_idx;
  logic              c_val, c_shd, c_dty, s_val, s_shd, s_dty;
  logic [TAG_W-1:0]  c_tag, s_tag, ctl_tag;
  logic [DATA_W-1:0] c_data, s_data, ctl_data, snp_udata;
  logic              ctl_we, ctl_shd, ctl_dty, snp_we, snp_udty;
  logic              w_en, w_shd, w_dty;
  logic [IDX_W-1:0]  w_idx;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;

  assign foreign = bus_valid_i && !bus_gnt_i;
  assign s_idx   = bus_addr_i[IDX_W-1:0];

  upd_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .done_o(cpu_done_o), .rdata_o(cpu_rdata_o),
    .breq_o(bus_req_o), .cmd_o(bus_cmd_o), .baddr_o(bus_addr_o), .bwdata_o(bus_wdata_o),
    .bgnt_i(bus_gnt_i), .foreign_i(foreign), .shared_i(bus_shared_i),
    .supply_i(bus_supply_i), .bdata_i(bus_data_i),
    .lidx_o(c_idx), .l_val_i(c_val), .l_tag_i(c_tag), .l_shd_i(c_shd),
    .l_dty_i(c_dty), .l_data_i(c_data),
    .lwe_o(ctl_we), .ltag_o(ctl_tag), .lshd_o(ctl_shd), .ldty_o(ctl_dty), .ldata_o(ctl_data)
  );

  upd_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
    .foreign_i(foreign), .cmd_i(bus_cmd_i), .tag_i(bus_addr_i[ADDR_W-1:IDX_W]),
    .data_i(bus_data_i), .l_val_i(s_val), .l_tag_i(s_tag), .l_dty_i(s_dty),
    .l_data_i(s_data), .shared_o(snp_shared_o), .supply_o(snp_supply_o),
    .sdata_o(snp_data_o), .upd_we_o(snp_we), .upd_dty_o(snp_udty), .upd_data_o(snp_udata)
  );

  // controller writes only in cycles without a foreign transaction: ports never collide
  always_comb begin
    if (snp_we) begin
      w_en = 1'b1; w_idx = s_idx; w_tag = s_tag;
      w_shd = 1'b1; w_dty = snp_udty; w_data = snp_udata;
    end else begin
      w_en = ctl_we; w_idx = c_idx; w_tag = ctl_tag;
      w_shd = ctl_shd; w_dty = ctl_dty; w_data = ctl_data;
    end
  end

  upd_line_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(w_en), .widx_i(w_idx), .wval_i(1'b1), .wtag_i(w_tag),
    .wshd_i(w_shd), .wdty_i(w_dty), .wdata_i(w_data),
    .aidx_i(c_idx), .a_val_o(c_val), .a_tag_o(c_tag), .a_shd_o(c_shd),
    .a_dty_o(c_dty), .a_data_o(c_data),
    .bidx_i(s_idx), .b_val_o(s_val), .b_tag_o(s_tag), .b_shd_o(s_shd),
    .b_dty_o(s_dty), .b_data_o(s_data)
  );

  logic unused_ok;
  assign unused_ok = s_shd;
endmodule

// File: rtl/upd_snoop_cache_chk.sv
module upd_snoop_cache_chk #(
  parameter int ADDR_W = 2,
  parameter int IDX_W  = 1,
  parameter int SETS   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_valid_i,
  input logic [1:0]        bus_cmd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o,
  input logic              cpu_done_o,
  input logic [SETS-1:0]   shd_q,
  input logic [SETS-1:0]   dty_q
);
  logic [IDX_W-1:0] b_idx;
  logic             foreign;
  assign b_idx   = bus_addr_i[IDX_W-1:0];
  assign foreign = bus_valid_i && !bus_gnt_i;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o));

  assert_own_not_shared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> !snp_shared_o);

  assert_supply_implies_shared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_shared_o);

  assert_supply_ends_sd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign && bus_cmd_i == 2'd1 && snp_supply_o |=> shd_q[$past(b_idx)] && dty_q[$past(b_idx)]);

  assert_snoop_update_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign && bus_cmd_i[1] && snp_shared_o |=> shd_q[$past(b_idx)] && !dty_q[$past(b_idx)]);

  assert_wthru_then_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i && bus_cmd_o == 2'd2 |=> cpu_done_o);

  assert_flush_then_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i && bus_cmd_o == 2'd3 |=> bus_req_o && bus_cmd_o == 2'd1);

  assert_done_idle_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !bus_req_o);
endmodule

bind upd_snoop_cache upd_snoop_cache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SETS(SETS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_valid_i(bus_valid_i),
  .bus_cmd_i(bus_cmd_i), .bus_addr_i(bus_addr_i), .snp_shared_o(snp_shared_o),
  .snp_supply_o(snp_supply_o), .cpu_done_o(cpu_done_o),
  .shd_q(u_store.shd_q), .dty_q(u_store.dty_q)
);

// File: tb/upd_snoop_cache_test.sv
`timescale 1ns/1ps
module upd_snoop_cache_test;
  localparam int N = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       c_req [N], c_we [N], c_done [N], c_breq [N], c_gnt [N], c_sh [N], c_sup [N];
  logic [1:0] c_addr [N], c_cmd [N], c_baddr [N];
  logic [7:0] c_wd [N], c_rd [N], c_bwd [N], c_sd [N];

  logic       g_any, sh_any, sup_any;
  int         g_idx, rr;
  logic [1:0] b_cmd, b_addr;
  logic [7:0] b_data, sup_data;
  logic [7:0] mem [4];

  int ntests = 0, nfail = 0, cyc = 0;
  int n_rd, n_wt, n_fl;
  logic sh_seen, iv_seen;

  for (genvar i = 0; i < N; i++) begin : g_cpu
    upd_snoop_cache uut (
      .clk_i(clk), .rst_ni(rst_n),
      .cpu_req_i(c_req[i]), .cpu_we_i(c_we[i]), .cpu_addr_i(c_addr[i]), .cpu_wdata_i(c_wd[i]),
      .cpu_done_o(c_done[i]), .cpu_rdata_o(c_rd[i]),
      .bus_req_o(c_breq[i]), .bus_gnt_i(c_gnt[i]), .bus_cmd_o(c_cmd[i]),
      .bus_addr_o(c_baddr[i]), .bus_wdata_o(c_bwd[i]),
      .bus_valid_i(g_any), .bus_cmd_i(b_cmd), .bus_addr_i(b_addr), .bus_data_i(b_data),
      .bus_shared_i(sh_any), .bus_supply_i(sup_any),
      .snp_shared_o(c_sh[i]), .snp_supply_o(c_sup[i]), .snp_data_o(c_sd[i])
    );
  end

  // round-robin arbiter and bus resolution
  always_comb begin
    g_any = 1'b0; g_idx = 0; sh_any = 1'b0; sup_any = 1'b0; sup_data = '0;
    for (int k = 0; k < N; k++) c_gnt[k] = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (rr + k) % N;
      if (!g_any && c_breq[j]) begin g_any = 1'b1; g_idx = j; end
    end
    if (g_any) c_gnt[g_idx] = 1'b1;
    for (int k = 0; k < N; k++) begin
      sh_any = sh_any | c_sh[k];
      if (c_sup[k] && !sup_any) sup_data = c_sd[k];
      sup_any = sup_any | c_sup[k];
    end
    b_cmd  = g_any ? c_cmd[g_idx] : 2'd0;
    b_addr = c_baddr[g_idx];
    b_data = (b_cmd == 2'd1) ? (sup_any ? sup_data : mem[b_addr]) : c_bwd[g_idx];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (g_any) begin
      rr <= (g_idx + 1) % N;
      if (b_cmd[1]) mem[b_addr] <= c_bwd[g_idx];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor and request-hold check
  logic       p_breq [N], p_gnt [N];
  logic [1:0] p_cmd [N], p_addr [N];
  always @(negedge clk) begin
    if (rst_n) begin
      if (g_any) begin
        case (b_cmd)
          2'd1: begin n_rd++; sh_seen = sh_any; iv_seen = sup_any; end
          2'd2: n_wt++;
          2'd3: n_fl++;
          default: ;
        endcase
      end
      for (int k = 0; k < N; k++) begin
        if (p_breq[k] && !p_gnt[k])
          chk(c_breq[k] && c_cmd[k] == p_cmd[k] && c_baddr[k] == p_addr[k],
              "R11 request held", int'({c_breq[k], c_cmd[k], c_baddr[k]}),
              int'({1'b1, p_cmd[k], p_addr[k]}));
        p_breq[k] = c_breq[k]; p_gnt[k] = c_gnt[k];
        p_cmd[k] = c_cmd[k]; p_addr[k] = c_addr[k] == c_addr[k] ? c_baddr[k] : c_baddr[k];
      end
    end
  end

  // bench model of line flags
  bit         mv [N][2], ms [N][2], md [N][2];
  int         mt [N][2];
  logic [7:0] gold [4], emem [4];
  logic [7:0] wcount = 8'd1;

  task automatic wait_done(input int c, output logic [7:0] rd);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!c_done[c] && t < 1000);
    if (t >= 1000) chk(1'b0, "R1 watchdog on done", 0, 1);
    rd = c_rd[c];
    c_req[c] = 1'b0;
  endtask

  task automatic op(input int c, input bit w, input int a);
    int idx = a % 2, tg = a / 2;
    bit hit, e_sh = 0, e_iv = 0, any;
    int e_fl = 0, e_rd = 0, e_wt = 0;
    logic [7:0] d, rd, exp_rd;
    d = wcount;
    if (w) wcount = wcount + 8'd1;
    hit = mv[c][idx] && mt[c][idx] == tg;
    if (!hit) begin
      if (mv[c][idx] && md[c][idx]) begin
        int va = mt[c][idx] * 2 + idx;
        e_fl = 1;
        emem[va] = gold[va];
        for (int o = 0; o < N; o++)
          if (o != c && mv[o][idx] && mt[o][idx] == mt[c][idx]) begin ms[o][idx] = 1; md[o][idx] = 0; end
        md[c][idx] = 0;
      end
      e_rd = 1;
      for (int o = 0; o < N; o++)
        if (o != c && mv[o][idx] && mt[o][idx] == tg) begin
          e_sh = 1;
          if (md[o][idx]) e_iv = 1;
          ms[o][idx] = 1;
        end
      mv[c][idx] = 1; mt[c][idx] = tg; ms[c][idx] = e_sh; md[c][idx] = e_iv;
    end
    exp_rd = gold[a];
    if (w) begin
      gold[a] = d;
      if (ms[c][idx]) begin
        e_wt = 1; emem[a] = d; any = 0;
        for (int o = 0; o < N; o++)
          if (o != c && mv[o][idx] && mt[o][idx] == tg) begin ms[o][idx] = 1; md[o][idx] = 0; any = 1; end
        ms[c][idx] = any; md[c][idx] = 0;
      end else begin
        md[c][idx] = 1;
      end
    end
    n_rd = 0; n_wt = 0; n_fl = 0; sh_seen = 0; iv_seen = 0;
    c_we[c] = w; c_addr[c] = 2'(a); c_wd[c] = d; c_req[c] = 1'b1;
    wait_done(c, rd);
    if (!w) chk(rd == exp_rd, hit ? "R2,R10 read data" : "R3,R7 read data", rd, exp_rd);
    chk(n_fl == e_fl, "R8,R12 flush count", n_fl, e_fl);
    chk(n_rd == e_rd, hit ? "R2 no bus read" : (w ? "R9 fill before write" : "R3 fill"), n_rd, e_rd);
    chk(n_wt == e_wt, e_wt ? "R5 write-through" : "R4 local write", n_wt, e_wt);
    if (e_rd) begin
      chk(sh_seen == e_sh, "R6 shared seen", sh_seen, e_sh);
      chk(iv_seen == e_iv, "R7 supply seen", iv_seen, e_iv);
    end
    for (int m = 0; m < 4; m++) chk(mem[m] == emem[m], "R7,R10 memory image", mem[m], emem[m]);
  endtask

  logic [7:0] pres [N];
  task automatic par_read(input int c, input int a);
    logic [7:0] rd;
    c_we[c] = 1'b0; c_addr[c] = 2'(a); c_req[c] = 1'b1;
    wait_done(c, rd);
    pres[c] = rd;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      ntests++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rr = 0;
    for (int k = 0; k < N; k++) begin
      c_req[k] = 0; c_we[k] = 0; c_addr[k] = 0; c_wd[k] = 0;
      p_breq[k] = 0; p_gnt[k] = 0; p_cmd[k] = 0; p_addr[k] = 0;
    end
    for (int m = 0; m < 4; m++) begin mem[m] = 0; emem[m] = 0; gold[m] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      chk(!c_done[k], "R1 done low", c_done[k], 0);
      chk(!c_breq[k], "R1 no request", c_breq[k], 0);
    end
    // stale-share and intervention sequence; a0/a2 conflict in set 0 (R12)
    op(0, 0, 0); op(0, 0, 2); op(0, 1, 2); op(0, 1, 2);
    op(1, 0, 2); op(2, 0, 2); op(0, 1, 2); op(0, 1, 2);
    op(0, 0, 0); op(1, 0, 0); op(2, 1, 2); op(2, 1, 2);
    op(1, 0, 2); op(1, 0, 0); op(0, 1, 2); op(0, 1, 0);
    // exhaustive single ops per processor, operation and address
    for (int c = 0; c < N; c++)
      for (int a = 0; a < 4; a++)
        for (int w = 0; w < 2; w++) op(c, w[0], a);
    // pseudo-random sweep
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(int'(lfsr[7:0]) % N, lfsr[9], int'(lfsr[12:11]));
    end
    // simultaneous reads of a dirty word: arbitration waits, multiple suppliers
    op(0, 0, 3); op(0, 1, 3);
    fork
      par_read(0, 3);
      par_read(1, 3);
      par_read(2, 3);
    join
    for (int k = 0; k < N; k++) chk(pres[k] == gold[3], "R7 concurrent read", pres[k], gold[3]);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule